// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the cycle-level control front end of a common-I/O synchronous SRAM organised as 128K words of 32 bits. It samples every synchronous control input on the rising clock edge. From the sampled values it decides, cycle by cycle, whether the memory array reads, writes (and into which byte lanes) or stays idle. It also decides whether the shared data bus is driven by the device or left in tri-state.

Two address strobes can open an access. An access opened by the processor-side strobe always begins with a read cycle and ignores the write controls in that cycle. The write controls are examined again at the next clock edge, and a write follows if they are active then. An access opened by the controller-side strobe acts on the write controls at once. A global write forces a full-word write. Otherwise a byte write enable qualifies four per-lane byte selects. An active-high sleep input stops new accesses and keeps the data bus released.

Top module: `sram_access_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release with idle inputs, rd_stb_o, wr_stb_o, byte_we_o and dq_oe_o are all 0.
- R2: The access is selected only when ce1_n_i=0, ce2_i=1 and ce3_n_i=0 are all sampled together. If any one is false, a strobe at that edge produces no rd_stb_o and no wr_stb_o.
- R3: If both adsp_n_i and adsc_n_i are sampled low, only the processor-strobe path is taken. The cycle after that edge is a read (rd_stb_o=1, wr_stb_o=0), whatever the write inputs are.
- R4: For a processor-strobe start, the write inputs sampled with the strobe are ignored. If at the next edge no strobe is sampled and the write inputs are active, wr_stb_o=1 in the cycle after that edge.
- R5: For a controller-strobe start (adsp_n_i high), active write inputs at that edge give wr_stb_o=1 in the next cycle. Inactive write inputs give rd_stb_o=1 instead.
- R6: A write with gw_n_i=0 sets byte_we_o=4'b1111, whatever bwe_n_i and bw_n_i are.
- R7: With gw_n_i=1 and bwe_n_i=0, byte_we_o[i] = ~bw_n_i[i]. Lane 0 is data bits 7:0 and lane 3 is bits 31:24. With gw_n_i=1 and bwe_n_i=1, no write occurs.
- R8: Read data belongs to the cycle after the read strobe. In that cycle dq_oe_o follows ~oe_n_i combinationally. In all other non-write cycles dq_oe_o is 0.
- R9: In any cycle with wr_stb_o=1, dq_oe_o=0 even if oe_n_i=0.
- R10: If zz_i is sampled high at an edge, no access starts and a pending processor-strobe write is dropped. While zz_i is high, dq_oe_o is 0.
- R11: byte_we_o is 0 in every cycle where wr_stb_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce1_n_i | input | 1 | Primary chip select, active low |
| ce2_i | input | 1 | Second chip select, active high |
| ce3_n_i | input | 1 | Third chip select, active low |
| adsp_n_i | input | 1 | Processor-side address strobe, active low |
| adsc_n_i | input | 1 | Controller-side address strobe, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte write enable, active low |
| bw_n_i | input | 4 | Per-lane byte selects, active low, bit 0 = bits 7:0 |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| zz_i | input | 1 | Sleep request, active high |
| rd_stb_o | output | 1 | Array read strobe |
| wr_stb_o | output | 1 | Array write strobe |
| byte_we_o | output | 4 | Per-lane array write enables |
| dq_oe_o | output | 1 | Data bus drive enable (0 = tri-state) |

## Verification
Each strobe is exercised alone and together with the other. Both are run with write controls active and inactive. This separates the immediate write of the controller path from the deferred write of the processor path, and shows the processor strobe winning when both are low. Separate patterns drive global write against conflicting byte controls, then several byte-select masks with and without the byte write enable, to separate override from per-lane qualification. Read data phases are run with output enable toggled and with a write overlapping them, to separate the output-enable rule from the forced tri-state on writes. Chip selects are each dropped alone, and sleep is raised against a new start, a pending write and a live data phase.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned LANE_W    = 8;

  // Sampled controls, converted to active-high
  typedef struct packed {
    logic sel;
    logic adsp;
    logic adsc;
    logic gw;
    logic bwe;
    logic zz;
  } ctrl_t;
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned NB = NUM_LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          adsp_n_i,
  input  logic          adsc_n_i,
  input  logic          gw_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] bw_n_i,
  input  logic          zz_i,
  output ctrl_t         q_o,
  output logic [NB-1:0] bw_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= '0;
      bw_q_o <= '0;
    end else begin
      q_o.sel  <= ~ce1_n_i & ce2_i & ~ce3_n_i;
      q_o.adsp <= ~adsp_n_i;
      q_o.adsc <= ~adsc_n_i;
      q_o.gw   <= ~gw_n_i;
      q_o.bwe  <= ~bwe_n_i;
      q_o.zz   <= zz_i;
      bw_q_o   <= ~bw_n_i;
    end
  end
endmodule

// File: rtl/sram_access_dec.sv
module sram_access_dec
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned NB = NUM_LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctrl_t         q_i,
  input  logic [NB-1:0] bw_q_i,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic [NB-1:0] byte_we_o
);
  logic start_p, start_c, wr_req, pend_q, pend_wr;

  assign start_p = q_i.sel & q_i.adsp & ~q_i.zz;
  // processor strobe has priority
  assign start_c = q_i.sel & ~q_i.adsp & q_i.adsc & ~q_i.zz;
  assign wr_req  = q_i.gw | (q_i.bwe & (|bw_q_i));
  assign pend_wr = pend_q & ~start_p & ~start_c & ~q_i.zz & wr_req;

  assign rd_stb_o = start_p | (start_c & ~wr_req);
  assign wr_stb_o = (start_c & wr_req) | pend_wr;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign byte_we_o[i] = wr_stb_o & (q_i.gw | (q_i.bwe & bw_q_i[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= start_p;
  end

  p_we_needs_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|byte_we_o) |-> wr_stb_o);
  p_gw_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && q_i.gw) |-> (&byte_we_o));
  p_sleep_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_i.zz |-> (!rd_stb_o && !wr_stb_o));
  p_deselect_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!q_i.sel && !pend_q) |-> (!rd_stb_o && !wr_stb_o));
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_stb_i,
  input  logic wr_stb_i,
  input  logic oe_n_i,
  input  logic zz_i,
  output logic dq_oe_o
);
  logic data_ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_ph_q <= 1'b0;
    else         data_ph_q <= rd_stb_i;
  end

  // write detection and sleep override output enable
  assign dq_oe_o = data_ph_q & ~oe_n_i & ~wr_stb_i & ~zz_i;

  p_tri_on_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_i |-> !dq_oe_o);
  p_drive_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> $past(rd_stb_i));
  p_sleep_tri_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |-> !dq_oe_o);
endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned NB = NUM_LANES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce1_n_i,
  input  logic          ce2_i,
  input  logic          ce3_n_i,
  input  logic          adsp_n_i,
  input  logic          adsc_n_i,
  input  logic          gw_n_i,
  input  logic          bwe_n_i,
  input  logic [NB-1:0] bw_n_i,
  input  logic          oe_n_i,
  input  logic          zz_i,
  output logic          rd_stb_o,
  output logic          wr_stb_o,
  output logic [NB-1:0] byte_we_o,
  output logic          dq_oe_o
);
  ctrl_t         q;
  logic [NB-1:0] bw_q;

  sram_in_reg #(.NB(NB)) u_in (
    .clk_i, .rst_ni, .ce1_n_i, .ce2_i, .ce3_n_i, .adsp_n_i, .adsc_n_i,
    .gw_n_i, .bwe_n_i, .bw_n_i, .zz_i, .q_o(q), .bw_q_o(bw_q)
  );

  sram_access_dec #(.NB(NB)) u_dec (
    .clk_i, .rst_ni, .q_i(q), .bw_q_i(bw_q),
    .rd_stb_o, .wr_stb_o, .byte_we_o
  );

  sram_bus_ctrl u_bus (
    .clk_i, .rst_ni, .rd_stb_i(rd_stb_o), .wr_stb_i(wr_stb_o),
    .oe_n_i, .zz_i, .dq_oe_o
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!rd_stb_o && !wr_stb_o && byte_we_o == '0 && !dq_oe_o));
  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));
endmodule

// File: tb/tb_sram_access_ctrl.sv
module tb_sram_access_ctrl;
  logic clk = 0, rst_ni = 0;
  logic ce1_n, ce2, ce3_n, adsp_n, adsc_n, gw_n, bwe_n, oe_n, zz;
  logic [3:0] bw_n;
  logic rd, wr, oe;
  logic [3:0] we;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sram_access_ctrl dut (
    .clk_i(clk), .rst_ni, .ce1_n_i(ce1_n), .ce2_i(ce2), .ce3_n_i(ce3_n),
    .adsp_n_i(adsp_n), .adsc_n_i(adsc_n), .gw_n_i(gw_n), .bwe_n_i(bwe_n),
    .bw_n_i(bw_n), .oe_n_i(oe_n), .zz_i(zz),
    .rd_stb_o(rd), .wr_stb_o(wr), .byte_we_o(we), .dq_oe_o(oe)
  );

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s rd/wr/oe/we act=%b exp=%b", req, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {rd, wr, oe, we};
  endfunction

  task automatic idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0; adsp_n = 1; adsc_n = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 1; zz = 0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    idle();
    repeat (2) @(posedge clk);
    #2 chk("R1 in reset", outs(), 7'b0);
    rst_ni = 1;
    tick();
    chk("R1 after release", outs(), 7'b0);
  endtask

  task automatic t_select();
    idle(); adsp_n = 0; ce1_n = 1; tick();
    chk("R2 ce1 off", outs(), 7'b0);
    idle(); adsc_n = 0; ce2 = 0; tick();
    chk("R2 ce2 off", outs(), 7'b0);
    idle(); adsp_n = 0; ce3_n = 1; tick();
    chk("R2 ce3 off", outs(), 7'b0);
    idle(); adsc_n = 0; tick();
    chk("R2 selected read", outs(), {3'b100, 4'h0});
    idle(); tick();
  endtask

  task automatic t_read_oe();
    idle(); adsc_n = 0; tick();
    chk("R5 adsc read", outs(), {3'b100, 4'h0});
    idle(); oe_n = 0; tick();
    chk("R8 data phase oe low", outs(), {3'b001, 4'h0});
    oe_n = 1; #1;
    chk("R8 oe async off", outs(), 7'b0);
    oe_n = 0; zz = 1; #1;
    chk("R10 sleep tri", outs(), 7'b0);
    zz = 0; #1;
    chk("R8 oe async on", outs(), {3'b001, 4'h0});
    tick();
    chk("R8 no drive later", outs(), 7'b0);
    idle();
  endtask

  task automatic t_adsp_write();
    idle(); adsp_n = 0; adsc_n = 0; gw_n = 0; tick();
    chk("R3 both strobes read", outs(), {3'b100, 4'h0});
    idle(); bwe_n = 0; bw_n = 4'b1010; oe_n = 0; tick();
    chk("R4 R7 R9 deferred byte write", outs(), {3'b010, 4'b0101});
    idle(); tick();
    chk("R11 no we idle", outs(), 7'b0);
    idle(); adsp_n = 0; tick();
    idle(); tick();
    chk("R4 no write inputs none", outs(), 7'b0);
  endtask

  task automatic t_adsc_write();
    idle(); adsc_n = 0; gw_n = 0; bwe_n = 1; bw_n = 4'hF; tick();
    chk("R6 gw full write", outs(), {3'b010, 4'hF});
    idle(); adsc_n = 0; gw_n = 0; bwe_n = 0; bw_n = 4'b1110; tick();
    chk("R6 gw overrides bytes", outs(), {3'b010, 4'hF});
    idle(); adsc_n = 0; bwe_n = 0; bw_n = 4'b0110; tick();
    chk("R7 lanes 0 and 3", outs(), {3'b010, 4'b1001});
    idle(); adsc_n = 0; bwe_n = 1; bw_n = 4'b0000; tick();
    chk("R7 bwe off is read", outs(), {3'b100, 4'h0});
    idle(); tick();
  endtask

  task automatic t_sleep();
    idle(); adsp_n = 0; zz = 1; tick();
    chk("R10 no start in sleep", outs(), 7'b0);
    idle(); adsp_n = 0; tick();
    chk("R10 setup read", outs(), {3'b100, 4'h0});
    idle(); zz = 1; gw_n = 0; oe_n = 0; tick();
    chk("R10 pending write dropped", outs(), 7'b0);
    idle(); tick();
    chk("R10 idle after sleep", outs(), 7'b0);
  endtask

  initial begin
    t_reset();
    t_select();
    t_read_oe();
    t_adsp_write();
    t_adsc_write();
    t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule